// File: doc/BRIEF.md
# Pin Serializer/Deserializer Engine

This block trades a wide parallel bus for four SPI pins. On each frame it takes a word from a chosen source and shifts it out on MOSI, most significant bit first. The source is either a software-written transmit register or the `par_in` pins. At the same time it collects the bits arriving on MISO. When the frame completes, the collected word is presented on the `par_out` pins and in a readable receive register. A remote shift register or SPI slave on the other end of the link can then mirror inputs and outputs that would otherwise need one pin each.

Frames can be launched in three ways. In continuous mode frames run back to back. In trigger mode a rising edge on `trig_in` starts a frame. In change mode a frame is sent whenever the selected source value differs from the last value sent. The frame length is programmable from 4 up to the data width. The serial clock can either stay parked low between frames or keep running all the time.

All settings live behind a small register port. Address 0 is the transmit data register (read/write). Address 1 is the receive data register (read-only). Address 2 is the configuration register (read/write). Reads are combinational.

Top module: `pser_engine`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `mosi` is 0, `par_out` is 0, and all three registers read back as 0.
- R2: A frame holds `cs_n` at 0 for its whole length and follows SPI mode 0. `sck` starts low. `mosi` presents the word most significant bit first and changes only when `sck` falls. There is exactly one rising `sck` edge per bit.
- R3: The frame length is configuration bits [5:0]. A value below 4 is treated as 4, and a value above DATA_W is treated as DATA_W. Only the low frame-length bits of the source are sent.
- R4: Configuration bit 8 selects the source: 0 selects the transmit register at address 0, and 1 selects the `par_in` pins.
- R5: The source value is captured when a frame starts. A change of the source during the frame does not alter the bits sent.
- R6: MISO is sampled on each rising `sck`, most significant bit first, and the result is zero-extended. `par_out` and the receive register at address 1 both take the received word together in the cycle after the last falling `sck`, and at no other time.
- R7: Configuration bits [7:6] = 1 (continuous) starts a new frame as soon as the previous one ends, with no further stimulus.
- R8: Bits [7:6] = 2 (trigger) starts one frame per rising edge of `trig_in`, after a two-flop synchroniser. Holding `trig_in` high starts no further frames.
- R9: In trigger mode, any number of rising edges during a frame cause exactly one further frame after that frame ends.
- R10: Bits [7:6] = 3 (change) starts a frame when the masked source differs from the last value sent, and no frame while they are equal. Bits above the frame length are ignored in the comparison.
- R11: Configuration bit 9 set keeps `sck` toggling while `cs_n` is high. With bit 9 clear, `sck` stays 0 between frames.
- R12: Bits [7:6] = 0 (off) starts no frame. A frame already running completes. The configuration register reads back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address (0 transmit, 1 receive, 2 configuration) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on `reg_addr` |
| par_in | input | DATA_W | Parallel data to serialise when pin source is selected |
| par_out | output | DATA_W | Last deserialised word |
| trig_in | input | 1 | Asynchronous hardware start trigger |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check, on every cycle, the following framing rules:
- MOSI holds steady except when SCK falls.
- SCK stays parked low between frames when the free-running clock is off.
- `par_out` moves only in the cycle after a frame completes.
- No frame begins while the start mode is off.

Only the bench scenarios can show the things that need a model of the far end or a count over many cycles:
- the bit order and the length clamp;
- the source selection and the mid-frame hold;
- the single catch-up frame after several triggers;
- the comparison against the last value sent in change mode.

// File: rtl/pser_pkg.sv
// Shared definitions for the pin serializer/deserializer engine.
// Assumes nothing beyond a SystemVerilog package scope.
package pser_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_CONT  = 2'd1,
        MODE_TRIG  = 2'd2,
        MODE_DELTA = 2'd3
    } start_mode_e;

    localparam logic [1:0] ADDR_TX  = 2'd0;
    localparam logic [1:0] ADDR_RX  = 2'd1;
    localparam logic [1:0] ADDR_CFG = 2'd2;

    localparam int CFG_W   = 10;
    localparam int MIN_LEN = 4;
endpackage

// File: rtl/pser_trig_sync.sv
// Two-flop synchroniser for the hardware trigger, plus rising-edge detect.
// Assumes trig_in may be asynchronous; rise is a one-cycle pulse.
module pser_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise
);
    logic [2:0] pipe_q;

    // Shift the trigger through two sync stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[1:0], trig_in};
    end

    assign rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/pser_shifter.sv
// SPI mode-0 frame engine: shifts out a left-aligned word and captures MISO.
// Assumes frame_bits is already clamped to 4..DATA_W and start is only
// honoured while ready. SCK half period is HALF_DIV system clocks.
module pser_shifter #(
    parameter int DATA_W   = 32,
    parameter int HALF_DIV = 2,
    parameter int LEN_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cont_clk,
    input  logic              start,
    input  logic [LEN_W-1:0]  frame_bits,
    input  logic [DATA_W-1:0] load_data,
    input  logic              miso,
    output logic              ready,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int DIV_W = $clog2(HALF_DIV) + 1;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    logic              busy_q;
    logic [DIV_W-1:0]  div_q;
    logic [LEN_W-1:0]  bit_q;
    logic [LEN_W-1:0]  nbits_q;
    logic [DATA_W-1:0] tx_sr_q;
    logic [DATA_W-1:0] rx_sr_q;
    logic              tick;

    assign tick  = (div_q == DIV_LAST);
    assign ready = !busy_q && !sck;
    assign cs_n  = !busy_q;
    assign mosi  = busy_q & tx_sr_q[DATA_W-1];

    // Frame sequencing: load, SCK generation, shifting and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
            nbits_q <= '0;
            tx_sr_q <= '0;
            rx_sr_q <= '0;
            rx_data <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && ready) begin
                busy_q  <= 1'b1;
                div_q   <= '0;
                bit_q   <= '0;
                nbits_q <= frame_bits;
                tx_sr_q <= load_data << (FULL_LEN - frame_bits);
                rx_sr_q <= '0;
            end else begin
                div_q <= tick ? '0 : div_q + 1'b1;
                if (busy_q) begin
                    if (tick) begin
                        if (!sck) begin
                            sck     <= 1'b1;
                            rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso};
                        end else begin
                            sck <= 1'b0;
                            if (bit_q == nbits_q - 1'b1) begin
                                busy_q  <= 1'b0;
                                done    <= 1'b1;
                                rx_data <= rx_sr_q;
                            end else begin
                                bit_q   <= bit_q + 1'b1;
                                tx_sr_q <= tx_sr_q << 1;
                            end
                        end
                    end
                end else if (cont_clk) begin
                    if (tick) sck <= ~sck;
                end else begin
                    sck <= 1'b0;
                end
            end
        end
    end

    // R2
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sck)) |-> $stable(mosi));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !sck));

    // R11
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cont_clk && $past(!cont_clk)) |-> !sck);
endmodule

// File: rtl/pser_engine.sv
// Pin serializer/deserializer top: register port, source select, start
// control (continuous, trigger edge, change in data) and parallel output.
// Assumes DATA_W is between 10 and 32 so the configuration word fits.
module pser_engine #(
    parameter int DATA_W   = 32,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] par_in,
    output logic [DATA_W-1:0] par_out,
    input  logic              trig_in,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    import pser_pkg::*;

    localparam int LEN_W = $clog2(DATA_W + 1);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    logic [DATA_W-1:0] tx_q, rx_q, last_sent_q, src_val, mask;
    logic [CFG_W-1:0]  cfg_q;
    logic [5:0]        len_raw;
    logic [LEN_W-1:0]  frame_bits;
    start_mode_e       mode;
    logic              src_pins, cont_clk;
    logic              trig_rise, pending_q, want, start, ready, frame_done;
    logic [DATA_W-1:0] rx_word;

    assign len_raw  = cfg_q[5:0];
    assign mode     = start_mode_e'(cfg_q[7:6]);
    assign src_pins = cfg_q[8];
    assign cont_clk = cfg_q[9];

    // Clamp the programmed frame length into the supported range.
    always_comb begin
        if (int'(len_raw) < MIN_LEN)      frame_bits = LEN_W'(MIN_LEN);
        else if (int'(len_raw) > DATA_W)  frame_bits = FULL_LEN;
        else                              frame_bits = LEN_W'(len_raw);
    end

    assign mask    = {DATA_W{1'b1}} >> (FULL_LEN - frame_bits);
    assign src_val = (src_pins ? par_in : tx_q) & mask;

    // Decide whether the selected start mode wants a frame now.
    always_comb begin
        case (mode)
            MODE_CONT:  want = 1'b1;
            MODE_TRIG:  want = pending_q;
            MODE_DELTA: want = (src_val != last_sent_q);
            default:    want = 1'b0;
        endcase
    end

    assign start = want && ready;

    // Register writes for transmit data and configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            cfg_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_TX)  tx_q  <= reg_wdata;
            if (reg_addr == ADDR_CFG) cfg_q <= reg_wdata[CFG_W-1:0];
        end
    end

    // Combinational register read mux.
    always_comb begin
        case (reg_addr)
            ADDR_TX:  reg_rdata = tx_q;
            ADDR_RX:  reg_rdata = rx_q;
            ADDR_CFG: reg_rdata = DATA_W'(cfg_q);
            default:  reg_rdata = '0;
        endcase
    end

    // Remember one trigger edge until a frame can start for it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pending_q <= 1'b0;
        else if (mode != MODE_TRIG) pending_q <= 1'b0;
        else if (trig_rise)         pending_q <= 1'b1;
        else if (start)             pending_q <= 1'b0;
    end

    // Keep the last value sent for change-in-data comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)     last_sent_q <= '0;
        else if (start) last_sent_q <= src_val;
    end

    // Publish the received word on the pins and in the register together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= '0;
            rx_q    <= '0;
        end else if (frame_done) begin
            par_out <= rx_word;
            rx_q    <= rx_word;
        end
    end

    pser_trig_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .rise    (trig_rise)
    );

    pser_shifter #(
        .DATA_W   (DATA_W),
        .HALF_DIV (HALF_DIV),
        .LEN_W    (LEN_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cont_clk   (cont_clk),
        .start      (start),
        .frame_bits (frame_bits),
        .load_data  (src_val),
        .miso       (miso),
        .ready      (ready),
        .sck        (sck),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .done       (frame_done),
        .rx_data    (rx_word)
    );

    // R6
    par_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_done) |-> $stable(par_out));

    // R12
    no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(mode) != MODE_OFF));
endmodule

// File: tb/pser_engine_bench.sv
`timescale 1ns/1ps
module pser_engine_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [DW-1:0] par_in = '0;
    logic [DW-1:0] par_out;
    logic          trig_in = 1'b0;
    logic          sck, mosi, cs_n;
    logic          miso = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int            frames = 0;
    logic [DW-1:0] mon_word = '0, last_word = '0;
    int            mon_bits = 0, last_bits = 0;
    logic [DW-1:0] slave_word = '0;
    int            slave_bits = 8;
    int            sidx = 0;

    always #2.5 clk = ~clk;

    pser_engine u_pser_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .par_in(par_in),
        .par_out(par_out), .trig_in(trig_in), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    // Far-end model: record MOSI on rising SCK, drive MISO MSB first.
    always @(negedge cs_n) begin
        mon_bits = 0;
        mon_word = '0;
        sidx = slave_bits - 1;
        miso = slave_word[sidx];
    end
    always @(posedge sck) if (!cs_n) begin
        mon_word = {mon_word[DW-2:0], mosi};
        mon_bits++;
    end
    always @(negedge sck) if (!cs_n) begin
        sidx--;
        miso = (sidx >= 0) ? slave_word[sidx] : 1'b0;
    end
    always @(posedge cs_n) begin
        frames++;
        last_word = mon_word;
        last_bits = mon_bits;
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cfg(input int len, input int mode, input bit pins, input bit fr);
        wr(2'd2, DW'(len) | (DW'(mode) << 6) | (DW'(pins) << 8) | (DW'(fr) << 9));
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1'b1;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic wait_frame(input int f0, input string req);
        int n = 0;
        while (frames <= f0 && n < 3000) begin @(negedge clk); n++; end
        check(frames > f0, req, DW'(frames), DW'(f0 + 1));
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cs_n === 1'b1, "R1 cs_n", DW'(cs_n), 1);
        check(sck === 1'b0 && mosi === 1'b0, "R1 sck/mosi", DW'({sck, mosi}), 0);
        check(par_out === '0, "R1 par_out", par_out, 0);
        for (int a = 0; a < 3; a++) begin
            reg_addr = 2'(a); #1;
            check(reg_rdata === '0, "R1 register", reg_rdata, 0);
        end
    endtask

    task automatic t_reg_source();
        int f0;
        wr(2'd0, 32'hA5);
        cfg(8, 2, 1'b0, 1'b0);
        reg_addr = 2'd2; #1;
        check(reg_rdata === 32'h0000_0088, "R12 cfg readback", reg_rdata, 32'h88);
        slave_word = 32'h3C; slave_bits = 8;
        f0 = frames;
        pulse_trig();
        wait_frame(f0, "R8 trigger frame");
        check(last_word === 32'hA5, "R4 register source", last_word, 32'hA5);
        check(last_bits == 8, "R2 edge count", DW'(last_bits), 8);
        check(par_out === 32'h3C, "R6 par_out", par_out, 32'h3C);
        reg_addr = 2'd1; #1;
        check(reg_rdata === 32'h3C, "R6 rx register", reg_rdata, 32'h3C);
    endtask

    task automatic t_pin_source();
        int f0;
        par_in = 32'hFFFF_F5A3;
        cfg(12, 2, 1'b1, 1'b0);
        slave_word = 32'hF0F; slave_bits = 12;
        f0 = frames;
        pulse_trig();
        wait_frame(f0, "R8 trigger frame");
        check(last_word === 32'h5A3 && last_bits == 12, "R4 pin source", last_word, 32'h5A3);
        check(par_out === 32'hF0F, "R6 par_out 12b", par_out, 32'hF0F);
    endtask

    task automatic t_hold();
        int f0;
        logic [DW-1:0] prev;
        par_in = 32'h1234;
        cfg(16, 2, 1'b1, 1'b0);
        slave_word = 32'hBEEF; slave_bits = 16;
        prev = par_out;
        f0 = frames;
        pulse_trig();
        @(negedge cs_n);
        repeat (6) @(negedge clk);
        par_in = 32'hFFFF;
        repeat (10) @(negedge clk);
        check(par_out === prev, "R6 par_out mid-frame", par_out, prev);
        wait_frame(f0, "R5 frame end");
        check(last_word === 32'h1234, "R5 source held", last_word, 32'h1234);
        check(par_out === 32'hBEEF, "R6 par_out 16b", par_out, 32'hBEEF);
    endtask

    task automatic t_len();
        int f0;
        par_in = 32'hFFFF_FFF9;
        cfg(2, 2, 1'b1, 1'b0);
        slave_bits = 4; slave_word = 32'h6;
        f0 = frames; pulse_trig(); wait_frame(f0, "R3 short");
        check(last_bits == 4 && last_word === 32'h9, "R3 clamp low", last_word, 32'h9);
        par_in = 32'hDEAD_BEEF;
        cfg(40, 2, 1'b1, 1'b0);
        slave_bits = 32; slave_word = 32'hC001_D00D;
        f0 = frames; pulse_trig(); wait_frame(f0, "R3 long");
        check(last_bits == 32 && last_word === 32'hDEAD_BEEF, "R3 clamp high",
              last_word, 32'hDEAD_BEEF);
        check(par_out === 32'hC001_D00D, "R6 par_out 32b", par_out, 32'hC001_D00D);
    endtask

    task automatic t_trig_multi();
        int f0;
        cfg(16, 2, 1'b1, 1'b0);
        slave_bits = 16;
        f0 = frames;
        pulse_trig();
        @(negedge cs_n);
        repeat (10) @(negedge clk);
        pulse_trig();
        repeat (10) @(negedge clk);
        pulse_trig();
        repeat (500) @(negedge clk);
        check(frames - f0 == 2, "R9 single catch-up", DW'(frames - f0), 2);
        f0 = frames;
        @(negedge clk); trig_in = 1'b1;
        repeat (400) @(negedge clk);
        check(frames - f0 == 1, "R8 held level", DW'(frames - f0), 1);
        trig_in = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_cont();
        int f0;
        cfg(8, 1, 1'b1, 1'b0);
        slave_bits = 8;
        f0 = frames;
        repeat (600) @(negedge clk);
        check(frames - f0 >= 4, "R7 back-to-back", DW'(frames - f0), 4);
        cfg(8, 0, 1'b1, 1'b0);
        repeat (100) @(negedge clk);
        f0 = frames;
        repeat (300) @(negedge clk);
        check(frames == f0 && cs_n === 1'b1, "R12 off mode", DW'(frames - f0), 0);
    endtask

    task automatic t_delta();
        int f0;
        par_in = 32'h77;
        cfg(8, 3, 1'b1, 1'b0);
        repeat (200) @(negedge clk);
        check(last_word === 32'h77, "R10 first send", last_word, 32'h77);
        f0 = frames;
        repeat (200) @(negedge clk);
        check(frames == f0, "R10 stable no frame", DW'(frames - f0), 0);
        par_in = 32'h78;
        repeat (200) @(negedge clk);
        check(frames - f0 == 1 && last_word === 32'h78, "R10 change frame", last_word, 32'h78);
        f0 = frames;
        par_in = 32'h178;
        repeat (200) @(negedge clk);
        check(frames == f0, "R10 masked bits ignored", DW'(frames - f0), 0);
    endtask

    task automatic t_cont_clk();
        int toggles;
        logic prev;
        cfg(8, 0, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        toggles = 0; prev = sck;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (sck !== prev) toggles++;
            prev = sck;
        end
        check(toggles >= 20 && cs_n === 1'b1, "R11 free-running sck", DW'(toggles), 25);
        cfg(8, 0, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        toggles = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (sck !== 1'b0) toggles++;
        end
        check(toggles == 0, "R11 parked sck", DW'(toggles), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        frames = 0;
        t_reset();
        t_reg_source();
        t_pin_source();
        t_hold();
        t_len();
        t_trig_multi();
        t_cont();
        t_delta();
        t_cont_clk();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule